// File: doc/BRIEF.md
# Four-Way Set-Associative Cache Controller

This block places a small, parameterised set-associative cache between a single CPU request port and a word-wide main-memory port. A byte address is split into tag, set index, word-in-line and byte offset. The indexed line of every way is compared with the tag in the same cycle. A hit is served from the cache. On a miss a whole line is fetched from memory, beat by beat, and the lookup is then replayed.

Two run-time inputs shape how writes are handled. `wb_mode_i` selects delayed write-back (1) or write-through (0). `wr_no_alloc_i` selects whether a write miss bypasses the cache entirely (1) or allocates a line (0). Both inputs are sampled during lookup. When a set has no free way, an external replacement selector names the victim way through a request/response pair. A modified victim is written back before the new line is fetched.

Top module: `sa_cache_ctrl`

## Requirements
- R1: With the defaults (16-bit byte address, 32-bit words, 4-word lines, 4 sets), the set is address bits [5:4] and the tag is address bits [15:6]. Lines with different tags and the same set coexist in different ways, and lines in other sets never disturb them.
- R2: After reset every line is invalid. The first access to any address reports a miss (`cpu_hit_o` low with `cpu_ack_o`) and causes no memory write.
- R3: A read whose line is valid in some way with an equal tag completes with `cpu_hit_o` high, returns the current word, and makes no memory or replacement request. At most one way hits.
- R4: A fill reads the 4 words of the line at the line-aligned address plus 0, 4, 8 and 12, in that order. Each beat completes when `mem_req_o` and `mem_ready_i` are both high. A request holds its address and direction until it completes.
- R5: On a miss, the lowest-numbered invalid way of the set is filled, and no replacement request is made while the set has an invalid way.
- R6: In write-through mode a write hit updates the cached word and performs exactly one memory write of that word at its address before the acknowledge.
- R7: In write-back mode a write hit causes no memory traffic and marks the line modified. Evicting a modified line writes its 4 words back (with the modified data) before any beat of the new fill. Evicting an unmodified line writes nothing.
- R8: With no-allocate selected, a write miss performs exactly one memory write and no read or replacement request, and leaves the cache unchanged, so a later read of that line misses.
- R9: `cpu_ack_o` is a single-cycle pulse, one per request. No memory or replacement request is active while it is high.
- R10: When the set is full, `repl_req_o` is held high with `repl_set_o` giving the set until `repl_valid_i`. The way given on `repl_way_i` is the one replaced, and lines in the other ways still hit.
- R11: With allocation selected, a write miss fills the line and then applies the write. In write-back mode memory keeps its old word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wb_mode_i | input | 1 | 1 write-back, 0 write-through |
| wr_no_alloc_i | input | 1 | 1 write misses bypass the cache |
| cpu_req_i | input | 1 | Request, held until acknowledge |
| cpu_we_i | input | 1 | 1 write, 0 read |
| cpu_addr_i | input | ADDR_W | Byte address |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_ack_o | output | 1 | Completion pulse |
| cpu_hit_o | output | 1 | First lookup hit, valid with acknowledge |
| cpu_rdata_o | output | DATA_W | Read word, valid with acknowledge |
| repl_req_o | output | 1 | Victim way wanted |
| repl_set_o | output | SET_W | Set needing a victim |
| repl_valid_i | input | 1 | Victim way supplied |
| repl_way_i | input | WAY_W | Victim way |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | 1 write beat, 0 read beat |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | DATA_W | Write beat data |
| mem_ready_i | input | 1 | Beat accepted; read data valid |
| mem_rdata_i | input | DATA_W | Read beat data |

## Verification
The hardest case to reach is the eviction of a modified line. It needs four distinct tags filled into one set, a write-back write hit on one of them, and a fifth tag that maps to that set while the replacement selector names exactly that way. The directed part of the bench builds this sequence with addresses 64 bytes apart and a selector forced to way 0, and then checks that the write-back beats come before the fill. The random part then confines addresses to 1 KB, so that each set holds 16 competing tags. It toggles modes and allocation on every access and lets the selector pick ways at random, so that dirty evictions after mode switches also occur.

// File: rtl/sa_cache_pkg.sv
`timescale 1ns/1ps
package sa_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_VICTIM,
    ST_WBACK,
    ST_FILL,
    ST_WTHRU
  } cache_st_e;
endpackage

// File: rtl/sa_prio_enc.sv
`timescale 1ns/1ps
module sa_prio_enc #(
  parameter int N = 4
) (
  input  logic [N-1:0]         vec_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    any_o = |vec_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/sa_tag_store.sv
`timescale 1ns/1ps
module sa_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 4,
  parameter int TAG_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(SETS)-1:0]      set_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [$clog2(WAYS)-1:0]      upd_way_i,
  input  logic                         fill_i,
  input  logic                         mark_dirty_i,
  output logic [WAYS-1:0]              hit_o,
  output logic [WAYS-1:0]              valid_o,
  output logic [WAYS-1:0]              dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]   tags_o
);
  localparam int WAY_W = $clog2(WAYS);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]  v_q;
    logic [SETS-1:0]  d_q;
    logic [TAG_W-1:0] t_q [SETS];
    logic             sel;

    assign sel = (upd_way_i == WAY_W'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= '0;
        d_q <= '0;
        for (int s = 0; s < SETS; s++) t_q[s] <= '0;
      end else if (fill_i && sel) begin
        v_q[set_i] <= 1'b1;
        d_q[set_i] <= 1'b0;
        t_q[set_i] <= tag_i;
      end else if (mark_dirty_i && sel) begin
        d_q[set_i] <= 1'b1;
      end
    end

    assign valid_o[w] = v_q[set_i];
    assign dirty_o[w] = d_q[set_i];
    assign tags_o[w]  = t_q[set_i];
    assign hit_o[w]   = v_q[set_i] && (t_q[set_i] == tag_i);
  end
endmodule

// File: rtl/sa_data_store.sv
`timescale 1ns/1ps
module sa_data_store #(
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32
) (
  input  logic                          clk_i,
  input  logic [$clog2(WAYS)-1:0]       rd_way_i,
  input  logic [$clog2(SETS)-1:0]       set_i,
  input  logic [$clog2(LINE_WORDS)-1:0] rd_word_i,
  output logic [DATA_W-1:0]             rd_data_o,
  input  logic                          we_i,
  input  logic [$clog2(WAYS)-1:0]       wr_way_i,
  input  logic [$clog2(LINE_WORDS)-1:0] wr_word_i,
  input  logic [DATA_W-1:0]             wr_data_i
);
  localparam int DEPTH = WAYS * SETS * LINE_WORDS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  rd_idx, wr_idx;

  assign rd_idx    = {rd_way_i, set_i, rd_word_i};
  assign wr_idx    = {wr_way_i, set_i, wr_word_i};
  assign rd_data_o = mem_q[rd_idx];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx] <= wr_data_i;
  end
endmodule

// File: rtl/sa_cache_ctrl.sv
`timescale 1ns/1ps
module sa_cache_ctrl
  import sa_cache_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 4,
  parameter int LINE_WORDS = 4,
  localparam int SET_W     = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_mode_i,
  input  logic              wr_no_alloc_i,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ack_o,
  output logic              cpu_hit_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              repl_req_o,
  output logic [SET_W-1:0]  repl_set_o,
  input  logic              repl_valid_i,
  input  logic [WAY_W-1:0]  repl_way_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WORD_W   = $clog2(LINE_WORDS);
  localparam int TAG_W    = ADDR_W - SET_W - WORD_W - BYTE_OFF;

  cache_st_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              missed_q;
  logic [WAY_W-1:0]  way_q;
  logic [WORD_W-1:0] beat_q;
  logic              ack_q, hit_q;
  logic [DATA_W-1:0] rdata_q;

  logic [TAG_W-1:0]  tag_a;
  logic [SET_W-1:0]  set_a;
  logic [WORD_W-1:0] word_a;
  assign tag_a  = addr_q[ADDR_W-1 -: TAG_W];
  assign set_a  = addr_q[BYTE_OFF+WORD_W +: SET_W];
  assign word_a = addr_q[BYTE_OFF +: WORD_W];

  logic [WAYS-1:0]             hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0]  tag_vec;
  logic                        hit_any, free_any;
  logic [WAY_W-1:0]            hit_idx, free_idx;
  logic [DATA_W-1:0]           rd_data;

  logic in_lookup, mem_hs, last_beat;
  assign in_lookup = (state_q == ST_LOOKUP);
  assign mem_hs    = mem_req_o && mem_ready_i;
  assign last_beat = (beat_q == WORD_W'(LINE_WORDS - 1));

  sa_prio_enc #(.N(WAYS)) u_hit_enc (
    .vec_i (hit_vec),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  sa_prio_enc #(.N(WAYS)) u_free_enc (
    .vec_i (~valid_vec),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  logic             ts_fill, ts_dirty;
  logic [WAY_W-1:0] ts_way;
  assign ts_fill  = (state_q == ST_FILL) && mem_hs && last_beat;
  assign ts_dirty = in_lookup && hit_any && we_q && wb_mode_i;
  assign ts_way   = in_lookup ? hit_idx : way_q;

  sa_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (set_a),
    .tag_i        (tag_a),
    .upd_way_i    (ts_way),
    .fill_i       (ts_fill),
    .mark_dirty_i (ts_dirty),
    .hit_o        (hit_vec),
    .valid_o      (valid_vec),
    .dirty_o      (dirty_vec),
    .tags_o       (tag_vec)
  );

  logic              ds_we;
  logic [WORD_W-1:0] ds_wword;
  logic [DATA_W-1:0] ds_wdata;
  assign ds_we    = (in_lookup && hit_any && we_q) || ((state_q == ST_FILL) && mem_hs);
  assign ds_wword = in_lookup ? word_a : beat_q;
  assign ds_wdata = in_lookup ? wdata_q : mem_rdata_i;

  sa_data_store #(
    .WAYS(WAYS), .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_data (
    .clk_i     (clk_i),
    .rd_way_i  (ts_way),
    .set_i     (set_a),
    .rd_word_i (in_lookup ? word_a : beat_q),
    .rd_data_o (rd_data),
    .we_i      (ds_we),
    .wr_way_i  (ts_way),
    .wr_word_i (ds_wword),
    .wr_data_i (ds_wdata)
  );

  // memory port is a pure function of state, so it stays stable until accepted
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tag_vec[way_q], set_a, beat_q, {BYTE_OFF{1'b0}}};
        mem_wdata_o = rd_data;
      end
      ST_FILL: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {tag_a, set_a, beat_q, {BYTE_OFF{1'b0}}};
      end
      ST_WTHRU: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {addr_q[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
        mem_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  assign repl_req_o  = (state_q == ST_VICTIM);
  assign repl_set_o  = set_a;
  assign cpu_ack_o   = ack_q;
  assign cpu_hit_o   = hit_q;
  assign cpu_rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      missed_q <= 1'b0;
      way_q    <= '0;
      beat_q   <= '0;
      ack_q    <= 1'b0;
      hit_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      ack_q <= 1'b0;
      hit_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          missed_q <= 1'b0;
          if (cpu_req_i && !ack_q) begin
            addr_q  <= cpu_addr_i;
            we_q    <= cpu_we_i;
            wdata_q <= cpu_wdata_i;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          beat_q <= '0;
          if (hit_any) begin
            if (!we_q) begin
              ack_q   <= 1'b1;
              hit_q   <= !missed_q;
              rdata_q <= rd_data;
              state_q <= ST_IDLE;
            end else if (wb_mode_i) begin
              ack_q   <= 1'b1;
              hit_q   <= !missed_q;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_WTHRU;
            end
          end else begin
            missed_q <= 1'b1;
            if (we_q && wr_no_alloc_i) begin
              state_q <= ST_WTHRU;
            end else if (free_any) begin
              way_q   <= free_idx;
              state_q <= ST_FILL;
            end else begin
              state_q <= ST_VICTIM;
            end
          end
        end
        ST_VICTIM: begin
          if (repl_valid_i) begin
            way_q   <= repl_way_i;
            state_q <= dirty_vec[repl_way_i] ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_hs) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_hs) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) state_q <= ST_LOOKUP;
          end
        end
        ST_WTHRU: begin
          if (mem_hs) begin
            ack_q   <= 1'b1;
            hit_q   <= !missed_q;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sa_cache_chk.sv
`timescale 1ns/1ps
module sa_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAYS   = 4,
  parameter int SET_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_ack_o,
  input logic              cpu_hit_o,
  input logic              repl_req_o,
  input logic [SET_W-1:0]  repl_set_o,
  input logic              repl_valid_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ready_i,
  input logic [WAYS-1:0]   hit_vec
);
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |=> !cpu_ack_o); // R9
  AST_QUIET_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ack_o |-> (!mem_req_o && !repl_req_o)); // R9
  AST_HIT_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> cpu_ack_o); // R3
  AST_ONE_WAY_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R4
  AST_WDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ready_i) |=> $stable(mem_wdata_o)); // R7
  AST_REPL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (repl_req_o && !repl_valid_i) |=> (repl_req_o && $stable(repl_set_o))); // R10
endmodule

bind sa_cache_ctrl sa_cache_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .SET_W(SET_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_ack_o    (cpu_ack_o),
  .cpu_hit_o    (cpu_hit_o),
  .repl_req_o   (repl_req_o),
  .repl_set_o   (repl_set_o),
  .repl_valid_i (repl_valid_i),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ready_i  (mem_ready_i),
  .hit_vec      (hit_vec)
);

// File: tb/sa_cache_ctrl_bench.sv
`timescale 1ns/1ps
module sa_cache_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wb_mode = 1'b1, no_alloc = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ack, cpu_hit;
  logic [31:0] cpu_rdata;
  logic        repl_req, repl_valid = 1'b0;
  logic [1:0]  repl_set, repl_way = '0;
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  sa_cache_ctrl u_sa_cache_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wb_mode_i(wb_mode), .wr_no_alloc_i(no_alloc),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ack_o(cpu_ack), .cpu_hit_o(cpu_hit), .cpu_rdata_o(cpu_rdata),
    .repl_req_o(repl_req), .repl_set_o(repl_set), .repl_valid_i(repl_valid), .repl_way_i(repl_way),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem_arr  [16384];
  logic [31:0] gold_arr [16384];
  int          log_n = 0, repl_n = 0, force_way = -1;
  logic        log_we   [64];
  logic [15:0] log_addr [64];
  logic [31:0] log_data [64];

  function automatic logic [31:0] init_val(int w);
    return 32'hA500_0000 ^ (w * 32'h0001_0107);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: decide acceptance at negedge; the request is held to the next edge
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (rst_n && mem_req && ($urandom % 3 != 0)) begin
      mem_ready = 1'b1;
      if (mem_we) mem_arr[mem_addr >> 2] = mem_wdata;
      else        mem_rdata = mem_arr[mem_addr >> 2];
      if (log_n < 64) begin
        log_we[log_n] = mem_we; log_addr[log_n] = mem_addr;
        log_data[log_n] = mem_we ? mem_wdata : mem_rdata;
      end
      log_n++;
    end
  end

  // replacement selector
  always @(negedge clk) begin
    repl_valid = 1'b0;
    if (rst_n && repl_req && ($urandom % 2 == 0)) begin
      repl_valid = 1'b1;
      repl_way   = (force_way >= 0) ? 2'(force_way) : 2'($urandom % 4);
      repl_n++;
    end
  end

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic h);
    @(negedge clk);
    log_n = 0;
    repl_n = 0;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    forever begin
      @(negedge clk);
      if (cpu_ack) break;
    end
    rd = cpu_rdata; h = cpu_hit;
    cpu_req = 1'b0;
    if (we) gold_arr[a >> 2] = d;
    @(negedge clk);
    chk(!cpu_ack, "R9 ack pulse", 32'(cpu_ack), 0);
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic exp_hit, input string req);
    logic [31:0] rd; logic h;
    access(1'b0, a, 0, rd, h);
    chk(rd == gold_arr[a >> 2], req, rd, gold_arr[a >> 2]);
    chk(h == exp_hit, req, 32'(h), 32'(exp_hit));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic h; int nw, nr;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 16384; i++) begin
      mem_arr[i] = init_val(i); gold_arr[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    chk(!cpu_ack && !mem_req && !repl_req, "R2 reset outputs", {cpu_ack, mem_req, repl_req}, 0);
    rst_n = 1'b1;

    // R2/R4: cold miss, 4 ordered read beats
    rd_chk(16'h0100, 1'b0, "R2 cold read");
    chk(log_n == 4, "R4 fill beats", log_n, 4);
    for (int b = 0; b < 4; b++)
      chk(!log_we[b] && log_addr[b] == 16'h0100 + 16'(4*b), "R4 beat order", log_addr[b], 16'h0100 + 16'(4*b));
    rd_chk(16'h0108, 1'b1, "R3 read hit");
    chk(log_n == 0 && repl_n == 0, "R3 hit no traffic", log_n, 0);

    // R1/R5: four tags into set 0, one line into set 1, no victim request
    rd_chk(16'h0140, 1'b0, "R1 tag5 set0");
    chk(repl_n == 0, "R5 free way used", repl_n, 0);
    rd_chk(16'h0180, 1'b0, "R1 tag6 set0");
    rd_chk(16'h01C0, 1'b0, "R1 tag7 set0");
    chk(repl_n == 0, "R5 free way used", repl_n, 0);
    rd_chk(16'h0110, 1'b0, "R1 set1 line");
    rd_chk(16'h0104, 1'b1, "R1 set0 lines coexist");
    rd_chk(16'h01CC, 1'b1, "R1 set0 way3 kept");

    // R7: write-back hit, quiet memory
    wb_mode = 1'b1;
    access(1'b1, 16'h0104, 32'hDEAD_BEEF, rd, h);
    chk(h && log_n == 0, "R7 wb hit no traffic", log_n, 0);
    rd_chk(16'h0104, 1'b1, "R7 wb data cached");

    // R7/R10: dirty victim way0 written back before fill
    force_way = 0;
    rd_chk(16'h0200, 1'b0, "R10 full set miss");
    chk(repl_n == 1, "R10 selector used", repl_n, 1);
    chk(log_n == 8, "R7 wb+fill beats", log_n, 8);
    for (int b = 0; b < 4; b++)
      chk(log_we[b] && log_addr[b] == 16'h0100 + 16'(4*b), "R7 writeback first", log_addr[b], 16'h0100 + 16'(4*b));
    chk(log_data[1] == 32'hDEAD_BEEF, "R7 modified word written", log_data[1], 32'hDEAD_BEEF);
    chk(!log_we[4] && log_addr[4] == 16'h0200, "R7 fill after wb", log_addr[4], 16'h0200);
    rd_chk(16'h0140, 1'b1, "R10 other way kept");
    rd_chk(16'h0100, 1'b0, "R10 victim gone");
    nw = 0;
    for (int b = 0; b < 4 && b < log_n; b++) nw += log_we[b];
    chk(nw == 0 && log_n == 4, "R7 clean victim no wb", log_n, 4);

    // R6: write-through hit
    wb_mode = 1'b0;
    access(1'b1, 16'h0148, 32'h1234_5678, rd, h);
    chk(h && log_n == 1 && log_we[0] && log_addr[0] == 16'h0148, "R6 one mem write", log_addr[0], 16'h0148);
    chk(mem_arr[16'h0148 >> 2] == 32'h1234_5678, "R6 memory updated", mem_arr[16'h0148 >> 2], 32'h1234_5678);
    rd_chk(16'h0148, 1'b1, "R6 cache updated");

    // R8: no-allocate write miss
    no_alloc = 1'b1;
    access(1'b1, 16'h0800, 32'hCAFE_0800, rd, h);
    chk(!h && log_n == 1 && log_we[0] && repl_n == 0, "R8 bypass write", log_n, 1);
    chk(mem_arr[16'h0800 >> 2] == 32'hCAFE_0800, "R8 memory written", mem_arr[16'h0800 >> 2], 32'hCAFE_0800);
    force_way = 2;
    rd_chk(16'h0800, 1'b0, "R8 cache unchanged");
    rd_chk(16'h0148, 1'b1, "R8 other lines intact");
    no_alloc = 1'b0;

    // R11: allocating write miss in write-back mode
    wb_mode = 1'b1;
    access(1'b1, 16'h0914, 32'h0BAD_F00D, rd, h);
    nr = 0;
    for (int b = 0; b < log_n && b < 64; b++) nr += !log_we[b];
    chk(!h && nr == 4 && log_n == 4 && repl_n == 0, "R11 fill only", log_n, 4);
    chk(mem_arr[16'h0914 >> 2] == init_val(16'h0914 >> 2), "R11 memory old", mem_arr[16'h0914 >> 2], init_val(16'h0914 >> 2));
    rd_chk(16'h0914, 1'b1, "R11 word written");

    // random mix
    force_way = -1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom & 32'h03FC);
      wb_mode  = 1'($urandom);
      no_alloc = 1'($urandom);
      if ($urandom % 2) access(1'b1, a, $urandom, rd, h);
      else begin
        access(1'b0, a, 0, rd, h);
        chk(rd == gold_arr[a >> 2], "R3 random read data", rd, gold_arr[a >> 2]);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule